// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block lets synchronous logic use a 32K x 8 asynchronous static RAM. The user side issues one command at a time through a valid/ready port: a write flag, a 15-bit word address and a byte of write data. A read answers with a one-cycle response pulse that carries the byte. The memory side drives the address bus, the active-low chip select, output enable and write strobe, and a data bus with its own drive-enable flag. A separate input bus returns data from the memory.

The memory's own timing limits are counted in clock cycles set by parameters. These are the read access length, the minimum write-strobe width, the data setup before the strobe ends, the address and data hold after it, and the turnaround gap between a read and a later bus drive. Every write is ended by the write strobe, with output enable kept high. The chip select rises on the same edge as the write strobe. The controller drives the data bus only while the memory's outputs are guaranteed to be in high impedance.

Top module: `sram_async_ctrl`

## Requirements
- R1: After reset, and whenever the controller is idle, `req_ready` is 1, all three strobes are 1, `mem_dout_en` is 0 and `rsp_valid` is 0. A command is taken on a clock edge where `req_valid` and `req_ready` are both 1. `req_write` = 1 selects a write and 0 selects a read.
- R2: A read holds `mem_ce_n` = 0, `mem_oe_n` = 0 and `mem_we_n` = 1 for exactly RD_CYCLES cycles. These start in the cycle after acceptance, and `mem_addr` shows the requested address throughout.
- R3: The byte on `mem_din` is sampled in the last read cycle. It appears on `rsp_rdata` while `rsp_valid` is 1 for exactly one cycle, and that cycle directly follows the read strobes.
- R4: A write holds `mem_ce_n` and `mem_we_n` both at 0 for max(WP_CYCLES, DS_CYCLES) cycles, and `mem_oe_n` stays 1 for the whole write.
- R5: `mem_dout_en` is 1, and `mem_dout` carries the write byte, for the last DS_CYCLES cycles of the strobe and for AH_CYCLES cycles after it. The memory therefore stores that byte.
- R6: `mem_addr` changes only on command acceptance. It is stable while `mem_ce_n` is 0 and through the write hold cycles.
- R7: `mem_dout_en` is never 1 while `mem_oe_n` is 0.
- R8: A write accepted at any time after a read completes first spends TURN_CYCLES cycles with all strobes at 1 and the bus undriven. Its strobe therefore falls TURN_CYCLES+1 cycles after acceptance.
- R9: A write with no read since reset or since the previous write starts its strobe in the cycle after acceptance.
- R10: At the end of a write, `mem_we_n` and `mem_ce_n` rise on the same clock edge.
- R11: While a command is in progress `req_ready` is 0, and a request presented then starts no memory cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Command present |
| req_ready | output | 1 | Controller idle, command may be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Word address |
| req_wdata | input | DW | Write byte |
| rsp_valid | output | 1 | One-cycle read response pulse |
| rsp_rdata | output | DW | Read byte |
| mem_addr | output | AW | Memory address bus |
| mem_ce_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_dout | output | DW | Data driven towards the memory |
| mem_dout_en | output | 1 | Drive enable for `mem_dout` |
| mem_din | input | DW | Data returned by the memory |

## Verification
On every clock the assertions check the following: the bus is never driven while output enable is low, and output enable stays high under a write strobe. Chip select and write strobe rise together. The address holds still under chip select and at the end of the strobe. The response is a single pulse that follows a read strobe. Saturating counters compare the strobe width, data setup, read length and read-to-drive gap against their configured minimums. Only the bench scenarios can show that the lengths are exact, not merely long enough. They also show that the correct bytes reach a memory model and come back, that the turnaround cost falls only on writes after reads, that the boundary addresses are carried, and that a request held during a busy read is ignored.

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl #(
  parameter int AW          = 15,
  parameter int DW          = 8,
  parameter int RD_CYCLES   = 3,
  parameter int WP_CYCLES   = 3,
  parameter int DS_CYCLES   = 2,
  parameter int AH_CYCLES   = 1,
  parameter int TURN_CYCLES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata,
  output logic [AW-1:0] mem_addr,
  output logic          mem_ce_n,
  output logic          mem_oe_n,
  output logic          mem_we_n,
  output logic [DW-1:0] mem_dout,
  output logic          mem_dout_en,
  input  logic [DW-1:0] mem_din
);

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int PULSE = max2(WP_CYCLES, DS_CYCLES);
  localparam int SETUP = PULSE - DS_CYCLES;
  localparam int MAXC  = max2(max2(RD_CYCLES, PULSE), max2(AH_CYCLES, TURN_CYCLES));
  localparam int CW    = $clog2(MAXC + 1);

  typedef enum logic [2:0] {S_IDLE, S_RD, S_TURN, S_WSET, S_WDAT, S_WHLD} st_t;

  st_t           st, nxt;
  logic [CW-1:0] cnt, nxt_cnt;
  logic          rd_recent;
  logic          last;

  assign req_ready = (st == S_IDLE);
  assign last      = (cnt == '0);

  always_comb begin
    nxt     = st;
    nxt_cnt = last ? cnt : cnt - CW'(1);
    case (st)
      S_IDLE:
        if (req_valid) begin
          if (!req_write) begin
            nxt = S_RD;   nxt_cnt = CW'(RD_CYCLES - 1);
          end else if (rd_recent) begin
            nxt = S_TURN; nxt_cnt = CW'(TURN_CYCLES - 1);
          end else if (SETUP > 0) begin
            nxt = S_WSET; nxt_cnt = CW'(SETUP - 1);
          end else begin
            nxt = S_WDAT; nxt_cnt = CW'(DS_CYCLES - 1);
          end
        end
      S_RD:
        if (last) nxt = S_IDLE;
      S_TURN:
        if (last) begin
          if (SETUP > 0) begin
            nxt = S_WSET; nxt_cnt = CW'(SETUP - 1);
          end else begin
            nxt = S_WDAT; nxt_cnt = CW'(DS_CYCLES - 1);
          end
        end
      S_WSET:
        if (last) begin
          nxt = S_WDAT; nxt_cnt = CW'(DS_CYCLES - 1);
        end
      S_WDAT:
        if (last) begin
          nxt = S_WHLD; nxt_cnt = CW'(AH_CYCLES - 1);
        end
      S_WHLD:
        if (last) nxt = S_IDLE;
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      cnt         <= '0;
      rd_recent   <= 1'b0;
      mem_ce_n    <= 1'b1;
      mem_oe_n    <= 1'b1;
      mem_we_n    <= 1'b1;
      mem_dout_en <= 1'b0;
      mem_addr    <= '0;
      mem_dout    <= '0;
      rsp_valid   <= 1'b0;
      rsp_rdata   <= '0;
    end else begin
      st          <= nxt;
      cnt         <= nxt_cnt;
      mem_ce_n    <= !(nxt inside {S_RD, S_WSET, S_WDAT});
      mem_oe_n    <= (nxt != S_RD);
      mem_we_n    <= !(nxt inside {S_WSET, S_WDAT});
      mem_dout_en <= (nxt inside {S_WDAT, S_WHLD});
      rsp_valid   <= (st == S_RD) && last;
      if (st == S_IDLE && req_valid) begin
        mem_addr <= req_addr;
        if (req_write) mem_dout <= req_wdata;
      end
      if (st == S_RD && last) begin
        rsp_rdata <= mem_din;
        rd_recent <= 1'b1;
      end else if (st == S_TURN && last) begin
        rd_recent <= 1'b0;
      end
    end
  end

  // Phase-length monitors for the checks below
  localparam int MW = 16;
  localparam logic [MW-1:0] SAT = '1;
  logic [MW-1:0] we_lo_n, oe_lo_n, oe_hi_n, ds_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_lo_n <= '0;
      oe_lo_n <= '0;
      oe_hi_n <= SAT;
      ds_n    <= '0;
    end else begin
      we_lo_n <= mem_we_n ? '0 : (we_lo_n == SAT ? SAT : we_lo_n + 1'b1);
      oe_lo_n <= mem_oe_n ? '0 : (oe_lo_n == SAT ? SAT : oe_lo_n + 1'b1);
      oe_hi_n <= !mem_oe_n ? '0 : (oe_hi_n == SAT ? SAT : oe_hi_n + 1'b1);
      ds_n    <= (mem_we_n || !mem_dout_en) ? '0 : (ds_n == SAT ? SAT : ds_n + 1'b1);
    end
  end

  // R1
  ready_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_ce_n && mem_we_n && mem_oe_n && !mem_dout_en));

  // R2
  rd_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_oe_n) |-> (oe_lo_n >= MW'(RD_CYCLES)));

  // R3
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ($past(!mem_oe_n) && mem_oe_n));

  // R3
  rsp_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  // R4
  oe_in_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (mem_oe_n && !mem_ce_n));

  // R4
  wp_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (we_lo_n >= MW'(PULSE)));

  // R5
  ds_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (ds_n >= MW'(DS_CYCLES) && mem_dout_en));

  // R6
  addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr));

  // R6
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> $stable(mem_addr));

  // R7
  no_contention_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_dout_en && !mem_oe_n));

  // R8
  turn_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_dout_en) |-> (oe_hi_n >= MW'(TURN_CYCLES)));

  // R10
  ce_we_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> $rose(mem_ce_n));

endmodule

// File: tb/test_sram_async_ctrl.sv
module test_sram_async_ctrl;
  localparam int RD = 3, WP = 3, DS = 2, AH = 1, TURN = 2;
  localparam int PULSE = (WP > DS) ? WP : DS;
  localparam int SETUP = PULSE - DS;
  localparam int NV = 12;
  // {write, addr[14:0], data[7:0]}; for reads data is the expected byte
  localparam logic [23:0] VEC [NV] = '{
    24'h8000A5, 24'hFFFF3C, 24'h8133FF, 24'h0000A5,
    24'h824400, 24'h7FFF3C, 24'h0133FF, 24'h024400,
    24'h80005A, 24'h8000C3, 24'h0000C3, 24'h0000C3
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [14:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic req_ready, rsp_valid, mem_ce_n, mem_oe_n, mem_we_n, mem_dout_en;
  logic [7:0]  rsp_rdata, mem_dout, mem_din;
  logic [14:0] mem_addr;

  int errors = 0, checks = 0;
  bit done = 0;
  bit rd_flag = 0;

  always #5 clk = ~clk;

  sram_async_ctrl #(.AW(15), .DW(8), .RD_CYCLES(RD), .WP_CYCLES(WP), .DS_CYCLES(DS),
                    .AH_CYCLES(AH), .TURN_CYCLES(TURN)) i_sram_async_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
    .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .mem_dout(mem_dout), .mem_dout_en(mem_dout_en), .mem_din(mem_din));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Memory model, 256 bytes indexed by the low address byte
  logic [7:0] mdl [256];
  bit p_wr = 0, p_den = 0, p_ce_lo = 0;
  logic [7:0]  p_dout = '0;
  logic [14:0] p_addr = '0;
  int we_run = 0, oe_run = 0, den_run = 0, den_start = 0;

  assign mem_din = (!mem_ce_n && !mem_oe_n && mem_we_n) ? mdl[mem_addr[7:0]] : 8'hEE;

  initial for (int i = 0; i < 256; i++) mdl[i] = 8'(i) ^ 8'h5A;

  always @(negedge clk) begin
    if (rst_n) begin
      if (p_wr && !(!mem_ce_n && !mem_we_n))
        mdl[p_addr[7:0]] = p_den ? p_dout : 8'hBD;
      if (mem_dout_en && !mem_oe_n) check(0, "R7 bus driven with oe low", 1, 0);
      if (!mem_we_n && !mem_oe_n) check(0, "R4 oe low during write", 0, 1);
      if ((p_ce_lo && !mem_ce_n) || p_den)
        if (mem_addr != p_addr) check(0, "R6 address moved", mem_addr, p_addr);
      if (!mem_we_n) we_run++;
      else if (we_run != 0) begin
        check(we_run == PULSE, "R4 strobe width", we_run, PULSE);
        check(mem_ce_n, "R10 ce rises with we", mem_ce_n, 1);
        we_run = 0;
      end
      if (!mem_oe_n) oe_run++;
      else if (oe_run != 0) begin
        check(oe_run == RD, "R2 read strobe length", oe_run, RD);
        oe_run = 0;
      end
      if (mem_dout_en) begin
        if (den_run == 0) den_start = we_run;
        den_run++;
      end else if (den_run != 0) begin
        check(den_run == DS + AH, "R5 drive length", den_run, DS + AH);
        check(den_start == SETUP + 1, "R5 drive start in strobe", den_start, SETUP + 1);
        den_run = 0;
      end
      p_wr    = !mem_ce_n && !mem_we_n;
      p_ce_lo = !mem_ce_n;
      p_den   = mem_dout_en;
      p_dout  = mem_dout;
      p_addr  = mem_addr;
    end
  end

  task automatic run_op(input logic wr, input logic [14:0] a, input logic [7:0] d);
    int n;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    n = 1;
    if (wr) begin
      while (mem_we_n && n < 50) begin @(negedge clk); n++; end
      if (rd_flag) check(n == TURN + 1, "R8 turnaround before write", n, TURN + 1);
      else         check(n == 1, "R9 direct write start", n, 1);
      check(mem_addr == a, "R6 write address", mem_addr, a);
      rd_flag = 0;
    end else begin
      check(mem_addr == a && !mem_oe_n, "R2 read address", mem_addr, a);
      while (!rsp_valid && n < 50) begin @(negedge clk); n++; end
      check(n == RD + 1, "R3 response timing", n, RD + 1);
      check(rsp_rdata == d, "R3 read data", rsp_rdata, d);
      @(negedge clk);
      check(!rsp_valid, "R3 single pulse", rsp_valid, 0);
      rd_flag = 1;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(req_ready && mem_ce_n && mem_oe_n && mem_we_n && !mem_dout_en && !rsp_valid,
          "R1 reset state", {req_ready, mem_ce_n, mem_oe_n, mem_we_n, mem_dout_en, rsp_valid},
          6'b111100);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready, "R1 ready after reset", req_ready, 1);

    for (int i = 0; i < NV; i++)
      run_op(VEC[i][23], VEC[i][22:8], VEC[i][7:0]);

    // R11: request held during a busy read is ignored
    begin
      int n;
      bit we_seen;
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      req_valid = 1'b1; req_write = 1'b0; req_addr = 15'h7FFF;
      @(negedge clk);
      req_write = 1'b1; req_addr = 15'h0133; req_wdata = 8'h77;
      n = 1; we_seen = 0;
      while (!rsp_valid && n < 50) begin
        check(!req_ready, "R11 ready low while busy", req_ready, 0);
        if (!mem_we_n) we_seen = 1;
        @(negedge clk); n++;
      end
      req_valid = 1'b0;
      check(rsp_rdata == 8'h3C, "R11 busy read data", rsp_rdata, 8'h3C);
      repeat (4) begin
        @(negedge clk);
        if (!mem_we_n || !mem_ce_n) we_seen = 1;
      end
      check(!we_seen, "R11 no cycle from busy request", we_seen, 0);
      check(req_ready && mem_ce_n, "R1 idle after read", req_ready, 1);
      rd_flag = 1;
    end
    run_op(1'b0, 15'h0133, 8'hFF);

    // R8: turnaround applies even after an idle gap
    repeat (6) @(negedge clk);
    run_op(1'b1, 15'h0055, 8'h9E);
    run_op(1'b1, 15'h0066, 8'h01);
    run_op(1'b0, 15'h0055, 8'h9E);
    run_op(1'b0, 15'h0066, 8'h01);

    repeat (4) @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule